// File: doc/BRIEF.md
# Cut-Through Transmit FIFO Start Controller

This block sits between a packet producer and a byte-serial transmitter. The producer pushes packet bytes into an internal 2048-entry FIFO and tags the final byte of each packet with an end mark. The controller decides when the transmitter may begin pulling the packet at the head of the FIFO. With cut-through allowed, the transmitter may start once enough bytes are buffered. In store-and-forward, it waits until a complete packet is present. Once started, the transmitter takes one byte per cycle by raising `rd_en`.

If the transmitter asks for a byte while the FIFO is empty and the end mark has not yet gone out, the packet has underrun. The block pulses an error, discards whatever of that packet still arrives, and latches a fallback flag. The flag forces store-and-forward for every later packet, so the producer's resend of the failed packet goes out whole. The flag stays set until a clear pulse or a reset. Store-and-forward is also forced when the retry budget is zero, when the enhancement enable is low, or when the threshold select asks for the 2048-byte setting.

Top module: `ctx_fifo_ctrl`

## Requirements
- R1: Bytes leave the FIFO in write order. `rd_data` and `rd_last` always show the head entry, with bit 8 of an entry being its end mark. An accepted `rd_en` during transmission removes that entry.
- R2: With cut-through in force, `thr_sel` selects the start threshold: 2'b11 gives 512 bytes, 2'b10 gives 1024 and 2'b01 gives 1740. `tx_start` rises one cycle after the buffered count first reaches the threshold.
- R3: In any mode, the presence of at least one end mark in the FIFO starts transmission, even below the threshold.
- R4: Store-and-forward is in force, and `saf_active` is 1, exactly when any of these holds: `thr_sel` is 2'b00, `enh_en` is 0, `retry_zero` is 1, or the fallback flag is set. In that mode no start occurs before an end mark is buffered.
- R5: An `rd_en` during transmission with an empty FIFO produces a one-cycle `underrun_err` and sets the fallback flag. All further bytes of that packet, up to and including its end mark, are dropped without `rd_en`. The next packet then waits for its own end mark.
- R6: The fallback flag persists until `clr_fallback` is pulsed or reset is applied.
- R7: When an underrun and `clr_fallback` fall in the same cycle, the fallback flag ends up set.
- R8: `wr_full` is 1 while 2048 bytes are held, and a write attempted then is ignored.
- R9: `rd_en` while not transmitting removes nothing.
- R10: Synchronous active-low reset empties the FIFO and clears the fallback flag, `tx_busy`, `tx_start` and `underrun_err`.
- R11: `tx_start` is a one-cycle pulse. `tx_busy` stays 1 from that cycle until the end-marked byte is taken or an underrun occurs. Mode inputs that change during transmission do not stop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Producer offers a byte |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Offered byte ends its packet |
| wr_full | output | 1 | FIFO holds 2048 bytes |
| thr_sel | input | 2 | Start threshold select |
| enh_en | input | 1 | Allows threshold-based cut-through |
| retry_zero | input | 1 | Retry budget is zero; forces store-and-forward |
| clr_fallback | input | 1 | Clears the post-underrun fallback flag |
| rd_en | input | 1 | Transmitter takes the head byte |
| rd_data | output | 8 | Head byte |
| rd_last | output | 1 | Head byte carries the end mark |
| tx_busy | output | 1 | Transmission of a packet in progress |
| tx_start | output | 1 | One-cycle pulse when transmission begins |
| underrun_err | output | 1 | One-cycle pulse on underrun |
| saf_active | output | 1 | Store-and-forward currently in force |

## Verification
Two functions can land on one clock edge: detecting an underrun, which sets the fallback flag, and a `clr_fallback` pulse, which clears it. The bench tracks the FIFO contents in its own model and raises `clr_fallback` exactly in the cycle where that model predicts an empty-FIFO read. It then expects `underrun_err` and a still-set `saf_active`. Simultaneous push and pop, and a write arriving in the same cycle as an underrun, come up repeatedly in the random phase. There the per-cycle model judges the head byte, the flags and the pulses on every cycle.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    // Transmit sequencing states
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SEND  = 2'd1,
        TX_FLUSH = 2'd2
    } tx_state_e;

    // Threshold select codes
    localparam logic [1:0] SEL_WHOLE = 2'b00;
    localparam logic [1:0] SEL_HIGH  = 2'b01;
    localparam logic [1:0] SEL_MID   = 2'b10;
    localparam logic [1:0] SEL_LOW   = 2'b11;

endpackage

// File: rtl/ctx_fifo.sv
module ctx_fifo #(
    parameter int DEPTH = 2048,          // power of two
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_last,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          head_last,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] eop_cnt,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] occ;
        logic [CW-1:0] eop_cnt;
    } fifo_st_t;

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    fifo_st_t      st_d, st_q;
    logic [DW:0]   mem_q [DEPTH];
    logic          push_ok, pop_ok;

    assign head_data = mem_q[st_q.rd_ptr][DW-1:0];
    assign head_last = mem_q[st_q.rd_ptr][DW];
    assign occ       = st_q.occ;
    assign eop_cnt   = st_q.eop_cnt;
    assign full      = (st_q.occ == FULL_CNT);
    assign empty     = (st_q.occ == '0);

    always_comb begin
        st_d    = st_q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        if (pop_ok)  st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        st_d.occ     = st_q.occ + CW'(push_ok) - CW'(pop_ok);
        st_d.eop_cnt = st_q.eop_cnt + CW'(push_ok && push_last)
                                    - CW'(pop_ok && head_last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Storage has no reset; only written entries are ever read
    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr_ptr] <= {push_last, push_data};
    end

    // R8: a write into a full FIFO without a pop leaves it full
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (st_q.occ == FULL_CNT));

    // R1: count never exceeds capacity, marks never exceed bytes
    a_r1_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.occ <= FULL_CNT) && (st_q.eop_cnt <= st_q.occ));

endmodule

// File: rtl/ctx_thresh.sv
module ctx_thresh
    import ctx_pkg::*;
#(
    parameter int DEPTH    = 2048,
    parameter int THR_HIGH = 1740,
    parameter int THR_MID  = 1024,
    parameter int THR_LOW  = 512,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input  logic [1:0]    thr_sel,
    input  logic          enh_en,
    input  logic          retry_zero,
    input  logic          fallback,
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] eop_cnt,
    output logic          saf,
    output logic          start_ok
);

    logic [CW-1:0] thr;

    always_comb begin
        unique case (thr_sel)
            SEL_LOW:  thr = CW'(THR_LOW);
            SEL_MID:  thr = CW'(THR_MID);
            SEL_HIGH: thr = CW'(THR_HIGH);
            default:  thr = CW'(DEPTH);
        endcase
        saf      = fallback || retry_zero || !enh_en || (thr_sel == SEL_WHOLE);
        start_ok = (eop_cnt != '0) || (!saf && (occ >= thr));
    end

endmodule

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
    import ctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    input  logic rd_en,
    input  logic clr_fallback,
    input  logic empty,
    input  logic head_last,
    output logic pop,
    output logic idle,
    output logic busy,
    output logic fallback,
    output logic tx_start,
    output logic underrun_err
);

    typedef struct packed {
        tx_state_e state;
        logic      fallback;
        logic      tx_start;
        logic      underrun;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.tx_start = 1'b0;
        ctl_d.underrun = 1'b0;
        pop            = 1'b0;
        unique case (ctl_q.state)
            TX_IDLE: begin
                if (start_ok) begin
                    ctl_d.state    = TX_SEND;
                    ctl_d.tx_start = 1'b1;
                end
            end
            TX_SEND: begin
                if (rd_en) begin
                    if (empty) begin
                        ctl_d.state    = TX_FLUSH;
                        ctl_d.underrun = 1'b1;
                    end else begin
                        pop = 1'b1;
                        if (head_last) ctl_d.state = TX_IDLE;
                    end
                end
            end
            TX_FLUSH: begin
                if (!empty) begin
                    pop = 1'b1;
                    if (head_last) ctl_d.state = TX_IDLE;
                end
            end
            default: ctl_d.state = TX_IDLE;
        endcase
        // setting on underrun takes priority over the clear request
        if (ctl_d.underrun)    ctl_d.fallback = 1'b1;
        else if (clr_fallback) ctl_d.fallback = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{state: TX_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign idle         = (ctl_q.state == TX_IDLE);
    assign busy         = (ctl_q.state == TX_SEND);
    assign fallback     = ctl_q.fallback;
    assign tx_start     = ctl_q.tx_start;
    assign underrun_err = ctl_q.underrun;

    // R11: start is a single-cycle pulse and coincides with busy
    a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (busy ##1 !tx_start));

    // R5: an underrun leaves fallback set and the packet being flushed
    a_r5_underrun_flush: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_err |-> (fallback && ctl_q.state == TX_FLUSH));

    // R6: fallback only drops on a clear request
    a_r6_fallback_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fallback && !clr_fallback) |=> fallback);

    // R7: simultaneous underrun and clear leaves fallback set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en && empty && clr_fallback) |=> (underrun_err && fallback));

endmodule

// File: rtl/ctx_fifo_ctrl.sv
module ctx_fifo_ctrl #(
    parameter int DEPTH    = 2048,
    parameter int DW       = 8,
    parameter int THR_HIGH = 1740,
    parameter int THR_MID  = 1024,
    parameter int THR_LOW  = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    output logic          wr_full,
    input  logic [1:0]    thr_sel,
    input  logic          enh_en,
    input  logic          retry_zero,
    input  logic          clr_fallback,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_last,
    output logic          tx_busy,
    output logic          tx_start,
    output logic          underrun_err,
    output logic          saf_active
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0] occ, eop_cnt;
    logic          empty, pop, idle, fallback, start_ok;

    ctx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data (wr_data),
        .push_last (wr_last),
        .pop       (pop),
        .head_data (rd_data),
        .head_last (rd_last),
        .occ       (occ),
        .eop_cnt   (eop_cnt),
        .full      (wr_full),
        .empty     (empty)
    );

    ctx_thresh #(
        .DEPTH    (DEPTH),
        .THR_HIGH (THR_HIGH),
        .THR_MID  (THR_MID),
        .THR_LOW  (THR_LOW)
    ) u_thresh (
        .thr_sel    (thr_sel),
        .enh_en     (enh_en),
        .retry_zero (retry_zero),
        .fallback   (fallback),
        .occ        (occ),
        .eop_cnt    (eop_cnt),
        .saf        (saf_active),
        .start_ok   (start_ok)
    );

    ctx_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_ok     (start_ok),
        .rd_en        (rd_en),
        .clr_fallback (clr_fallback),
        .empty        (empty),
        .head_last    (rd_last),
        .pop          (pop),
        .idle         (idle),
        .busy         (tx_busy),
        .fallback     (fallback),
        .tx_start     (tx_start),
        .underrun_err (underrun_err)
    );

    // R4: store-and-forward with no complete packet never starts
    a_r4_saf_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && eop_cnt == '0 && saf_active) |=> !tx_start);

    // R9: while idle with data buffered, the head entry does not move
    a_r9_idle_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && occ != '0) |=> ($stable(rd_data) && $stable(rd_last)));

    // R10: reset leaves no pulse and no transmission behind
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!tx_start && !underrun_err && !tx_busy && !wr_full));

endmodule

// File: tb/ctx_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module ctx_fifo_ctrl_tb_top;

    localparam int DEPTH = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wv = 1'b0, wl = 1'b0;
    logic [7:0] wd = '0;
    logic [1:0] sel = 2'b01;
    logic       en = 1'b1, rz = 1'b0, clr = 1'b0, rd = 1'b0;
    logic       wr_full, rd_last, tx_busy, tx_start, underrun_err, saf_active;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    ctx_fifo_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_data(wd), .wr_last(wl),
        .wr_full(wr_full), .thr_sel(sel), .enh_en(en), .retry_zero(rz),
        .clr_fallback(clr), .rd_en(rd), .rd_data(rd_data), .rd_last(rd_last),
        .tx_busy(tx_busy), .tx_start(tx_start), .underrun_err(underrun_err),
        .saf_active(saf_active)
    );

    int vectors = 0, fails = 0;
    logic [8:0] q[$];
    int  m_state = 0;        // 0 idle, 1 sending, 2 flushing
    bit  m_fb = 0, e_start = 0, e_und = 0, auto_clr = 0;
    int  pkt_wr = 0, start_at = -1;
    logic [7:0] data_ctr = 8'd1;

    function automatic int thr_of(logic [1:0] s);
        case (s)
            2'b11: return 512;
            2'b10: return 1024;
            2'b01: return 1740;
            default: return DEPTH;
        endcase
    endfunction

    function automatic bit saf_of(bit fb);
        return fb || rz || !en || (sel == 2'b00);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(tx_start == e_start, "R2 R3 R4 tx_start", tx_start, e_start);
        chk(underrun_err == e_und, "R5 underrun_err", underrun_err, e_und);
        chk(tx_busy == (m_state == 1), "R11 tx_busy", tx_busy, m_state == 1);
        chk(wr_full == (q.size() == DEPTH), "R8 wr_full", wr_full, q.size() == DEPTH);
        chk(saf_active == saf_of(m_fb), "R4 R6 saf_active", saf_active, saf_of(m_fb));
        if (q.size() > 0)
            chk({rd_last, rd_data} == q[0], "R1 head entry", {rd_last, rd_data}, q[0]);
        if (tx_start && start_at < 0) start_at = pkt_wr;
    endtask

    task automatic tick();
        bit emp, saf, st, und, pop, hl, push, nfb;
        int ns;
        if (auto_clr) clr = (m_state == 1) && rd && (q.size() == 0);
        emp  = (q.size() == 0);
        hl   = !emp && q[0][8];
        saf  = saf_of(m_fb);
        st   = (m_state == 0) &&
               (eop_count() > 0 || (!saf && q.size() >= thr_of(sel)));
        und  = (m_state == 1) && rd && emp;
        pop  = ((m_state == 1) && rd && !emp) || ((m_state == 2) && !emp);
        push = wv && (q.size() < DEPTH);
        ns   = m_state;
        case (m_state)
            0: if (st) ns = 1;
            1: if (und) ns = 2; else if (pop && hl) ns = 0;
            default: if (pop && hl) ns = 0;
        endcase
        nfb = und ? 1'b1 : (clr ? 1'b0 : m_fb);
        @(posedge clk);
        if (!rst_n) begin
            q.delete(); m_state = 0; m_fb = 0; e_start = 0; e_und = 0;
        end else begin
            if (pop) void'(q.pop_front());
            if (push) q.push_back({wl, wd});
            m_state = ns; m_fb = nfb; e_start = st; e_und = und;
        end
        @(negedge clk);
        compare();
    endtask

    function automatic int eop_count();
        int n = 0;
        foreach (q[i]) if (q[i][8]) n++;
        return n;
    endfunction

    task automatic idle(int n);
        wv = 0; wl = 0;
        repeat (n) tick();
    endtask

    task automatic send_pkt(int len, int gap_at, int gap_len);
        start_at = -1;
        for (int i = 0; i < len; i++) begin
            if (gap_len > 0 && i == gap_at) begin
                wv = 0; wl = 0;
                repeat (gap_len) tick();
            end
            wv = 1; wd = data_ctr; data_ctr = data_ctr + 8'd7;
            wl = (i == len - 1); pkt_wr = i + 1;
            tick();
        end
        wv = 0; wl = 0;
    endtask

    task automatic pulse_clr();
        clr = 1; tick(); clr = 0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) tick();
        rst_n = 1;
        // R10: clean reset state
        chk(!tx_busy && !tx_start && !underrun_err && !wr_full && !saf_active,
            "R10 reset outputs", {tx_busy, tx_start, underrun_err, wr_full, saf_active}, 0);

        // R2: cut-through thresholds, transmitter pulls every cycle
        rd = 1;
        sel = 2'b11; send_pkt(600, 0, 0);
        chk(start_at == 513, "R2 start at 512 bytes", start_at, 513);
        idle(700);
        sel = 2'b10; send_pkt(1100, 0, 0);
        chk(start_at == 1025, "R2 start at 1024 bytes", start_at, 1025);
        idle(1200);
        sel = 2'b01; send_pkt(1800, 0, 0);
        chk(start_at == 1741, "R2 start at 1740 bytes", start_at, 1741);
        idle(1900);

        // R3: short packet starts on its end mark
        send_pkt(300, 0, 0); idle(2);
        chk(start_at == 300, "R3 start on end mark", start_at, 300);
        idle(400);

        // R5: underrun, flush of the rest, retry goes whole
        sel = 2'b11; send_pkt(700, 520, 600); idle(20);
        send_pkt(700, 0, 0); idle(2);
        chk(start_at == 700, "R5 retry waits for whole packet", start_at, 700);
        idle(800);
        chk(saf_active == 1, "R6 fallback sticky", saf_active, 1);
        pulse_clr();
        chk(saf_active == 0, "R6 fallback cleared", saf_active, 0);

        // R7: clear lands in the underrun cycle
        auto_clr = 1; send_pkt(700, 520, 600); idle(20); auto_clr = 0; clr = 0;
        chk(saf_active == 1, "R7 underrun beats clear", saf_active, 1);
        tick();
        pulse_clr();

        // R4: each forcing input imposes store-and-forward
        rz = 1; send_pkt(600, 0, 0); idle(2);
        chk(start_at == 600, "R4 retry_zero forces whole packet", start_at, 600);
        idle(700); rz = 0;
        en = 0; send_pkt(600, 0, 0); idle(2);
        chk(start_at == 600, "R4 enh_en low forces whole packet", start_at, 600);
        idle(700); en = 1;
        sel = 2'b00; send_pkt(600, 0, 0); idle(2);
        chk(start_at == 600, "R4 select 00 forces whole packet", start_at, 600);
        idle(700);

        // R9: rd_en while idle takes nothing
        rd = 0; sel = 2'b00;
        wv = 1; wl = 0; wd = 8'hA5; tick();
        wd = 8'h3C; tick(); wv = 0;
        rd = 1; repeat (6) tick();
        chk({rd_last, rd_data} == 9'h0A5, "R9 head kept while idle", {rd_last, rd_data}, 9'h0A5);
        wv = 1; wl = 1; wd = 8'h77; tick(); wv = 0; wl = 0;
        idle(20);

        // R8: fill to capacity, extra writes dropped
        rd = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            wv = 1; wl = 0; wd = 8'(i); tick();
        end
        wl = 1; tick(); wv = 0; wl = 0;
        chk(wr_full == 1, "R8 full flag", wr_full, 1);
        chk(rd_last == 0, "R8 end mark dropped when full", rd_last, 0);
        sel = 2'b01; rd = 1; idle(DEPTH + 20);
        wv = 1; wl = 1; wd = 8'h11; tick(); wv = 0; wl = 0;
        idle(10);
        pulse_clr();

        // Random phase, fixed seed
        begin
            int remain = 0;
            for (int c = 0; c < 40000; c++) begin
                if (c % 500 == 0) sel = 2'($urandom);
                if (c % 97 == 0) begin
                    en = ($urandom % 10) != 0;
                    rz = ($urandom % 10) == 0;
                end
                if (remain == 0) remain = 1 + ($urandom % 700);
                wv = (($urandom % 4) != 0) && (q.size() < DEPTH);
                wd = 8'($urandom); wl = (remain == 1);
                rd = ($urandom % 8) != 0;
                clr = ($urandom % 300) == 0;
                tick();
                if (wv) remain--;
            end
            wv = 0; wl = 0; clr = 0;
        end

        summary();
        $finish;
    end

endmodule